// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sits beside a processor core and turns its wait-for-interrupt (WFI) and wait-for-event (WFE) requests into a low-power state. Three configuration levels set the depth of that state: deep-sleep select, power-down select and low-power-regulator select. Light sleep gates only the core clock. Stop gates every main-domain clock and the oscillators, and can run the regulator in its low-power mode. Standby switches the main domain off. Each state has its own set of wake sources, and leaving Standby works like a fresh start.

The controller also returns to sleep when an interrupt handler hands control back to thread mode, if that option is set. It keeps a one-bit event record, so a WFE that follows an event falls through without sleeping. It can turn the arrival of any new pending interrupt into an event. After Stop or Standby it hands the system clock to the internal RC oscillator. Leaving Standby raises a reset pulse of fixed length and sets a sticky flag that software can read and clear afterwards.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (run). Core clock, peripheral clock, oscillator and main power enables are all 1. `reg_lp`, `sys_rst_req` and `sb_flag` are 0, and `clk_sel_rc` is 1.
- R2: In run with `cfg_deep`=0, a WFI or WFE request moves `mode` to 1 (sleep) on the next clock. In sleep the core clock is off and the peripheral clock stays on.
- R3: In run with `cfg_deep`=1 and `cfg_pdown`=0, a request moves `mode` to 2 (stop). Core clock, peripheral clock and oscillator are all off. `reg_lp` equals the `cfg_lpreg` value captured at the request.
- R4: In run with `cfg_deep`=1 and `cfg_pdown`=1, a request moves `mode` to 3 (standby). Main power and every clock enable are 0.
- R5: Sleep entered by WFI returns to run only when some bit of `irq_pend & irq_en` is set. A pending interrupt whose enable is 0 has no effect.
- R6: Stop is left only when some bit of `ext_line & ext_en` is set. Enabled interrupts, wake pins and external lines whose enable is 0 leave `mode` at 2.
- R7: On a stop exit with the regulator in low-power mode, `mode` reads 4 (regulator settle) for exactly SETTLE_CYC cycles and then 0. With the normal regulator, `mode` goes straight to 0.
- R8: Leaving stop or standby sets `clk_sel_rc` to 1. A `clk_main_req` pulse in run clears it.
- R9: Standby is left on a 0-to-1 edge of any wake pin whose `wpin_en` bit is set, on any `bkp_evt` bit, or on `wdg_rst`. A pin already high at entry, or a disabled pin, does not wake it.
- R10: On a standby exit, `mode` reads 5 (restart) with `sys_rst_req`=1 for exactly RESTART_CYC cycles and then 0. `sb_flag` is set and stays set until a `sb_flag_clr` pulse.
- R11: A `handler_ret` pulse in run enters sleep (`mode` 1) only when `cfg_sleep_on_ret` is 1. Otherwise `mode` stays 0.
- R12: Sleep entered by WFE also ends on an `evt_in` pulse. When `cfg_pend_evt` is 1 it also ends on a 0-to-1 change of any `irq_pend` bit, enabled or not. When `cfg_pend_evt` is 0, such a change leaves `mode` at 1.
- R13: A WFE issued while an event is recorded, or in the same cycle as an event, does not sleep and clears the record. The next WFE then enters sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_deep | input | 1 | Deep-sleep select |
| cfg_pdown | input | 1 | Power down in deep sleep (standby) |
| cfg_lpreg | input | 1 | Low-power regulator in stop |
| cfg_sleep_on_ret | input | 1 | Re-enter sleep on handler return |
| cfg_pend_evt | input | 1 | New pending interrupt counts as an event |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| handler_ret | input | 1 | Handler returned to thread mode |
| evt_in | input | 1 | Event pulse |
| irq_pend | input | NUM_IRQ | Interrupt pending lines |
| irq_en | input | NUM_IRQ | Interrupt enables |
| ext_line | input | NUM_EXT | External interrupt lines |
| ext_en | input | NUM_EXT | External line interrupt/event enables |
| wpin | input | NUM_WPIN | Wake pins |
| wpin_en | input | NUM_WPIN | Per-pin wake enables |
| bkp_evt | input | NUM_BKP | Alarm, timer wake, tamper and time-stamp events |
| wdg_rst | input | 1 | Watchdog reset request |
| clk_main_req | input | 1 | Switch system clock back to the main source |
| sb_flag_clr | input | 1 | Clear the standby flag |
| mode | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| reg_lp | output | 1 | Regulator in low-power mode |
| main_pwr_en | output | 1 | Main domain power enable |
| clk_sel_rc | output | 1 | Internal RC oscillator selected as system clock |
| sys_rst_req | output | 1 | System reset pulse after standby |
| sb_flag | output | 1 | Sticky standby-exit flag |

## Verification
The event record is where two functions can meet in one cycle: an arriving event can set it while a WFE request consumes it. The bench drives `wfe_req` and `evt_in` on the same edge. It expects `mode` to stay 0, and it expects a second WFE to enter sleep, which shows the record was cleared and not left set. The bench also records an event well before a WFE, to show the record is kept across idle cycles.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  // State codes are visible on the mode port.
  typedef enum logic [2:0] {
    M_RUN     = 3'd0,
    M_SLEEP   = 3'd1,
    M_STOP    = 3'd2,
    M_STBY    = 3'd3,
    M_SETTLE  = 3'd4,
    M_RESTART = 3'd5
  } lpm_mode_e;
endpackage

// File: rtl/lpm_wake_src.sv
module lpm_wake_src #(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_EXT  = 4,
  parameter int NUM_WPIN = 2,
  parameter int NUM_BKP  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  input  logic [NUM_IRQ-1:0]  irq_en,
  input  logic [NUM_EXT-1:0]  ext_line,
  input  logic [NUM_EXT-1:0]  ext_en,
  input  logic [NUM_WPIN-1:0] wpin,
  input  logic [NUM_WPIN-1:0] wpin_en,
  input  logic [NUM_BKP-1:0]  bkp_evt,
  input  logic                wdg_rst,
  output logic                irq_wake,
  output logic                pend_rise,
  output logic                ext_wake,
  output logic                stby_wake
);
  logic [NUM_IRQ-1:0]  pend_q;
  logic [NUM_WPIN-1:0] pin_q;
  logic [NUM_WPIN-1:0] pin_edge;

  // Previous samples for edge detection; they are always sampled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pin_q  <= '0;
    end else begin
      pend_q <= irq_pend;
      pin_q  <= wpin;
    end
  end

  // One edge detector per wake pin, each gated by its own enable.
  for (genvar g = 0; g < NUM_WPIN; g++) begin : g_pin
    assign pin_edge[g] = wpin_en[g] & wpin[g] & ~pin_q[g];
  end

  assign irq_wake  = |(irq_pend & irq_en);
  assign pend_rise = |(irq_pend & ~pend_q);
  assign ext_wake  = |(ext_line & ext_en);
  assign stby_wake = (|pin_edge) | (|bkp_evt) | wdg_rst;
endmodule

// File: rtl/lpm_event_reg.sv
module lpm_event_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  input  logic pend_rise,
  input  logic pend_evt_en,
  input  logic consume,
  output logic evt_now,
  output logic evt_pend
);
  logic rec_q, rec_d, rec_en;

  assign evt_now  = evt_in | (pend_evt_en & pend_rise);
  assign evt_pend = rec_q | evt_now;

  // Consumption wins over a new event in the same cycle.
  always_comb begin
    rec_en = consume | evt_now;
    rec_d  = consume ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= 1'b0;
    else if (rec_en) rec_q <= rec_d;
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC  = 6,  // must be at least 1
  parameter int RESTART_CYC = 4   // must be at least 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_deep,
  input  logic      cfg_pdown,
  input  logic      cfg_lpreg,
  input  logic      cfg_soe,
  input  logic      wfi_req,
  input  logic      wfe_req,
  input  logic      handler_ret,
  input  logic      irq_wake,
  input  logic      ext_wake,
  input  logic      stby_wake,
  input  logic      evt_now,
  input  logic      evt_pend,
  input  logic      clk_main_req,
  input  logic      sb_flag_clr,
  output logic      evt_consume,
  output lpm_mode_e mode_o,
  output logic      core_clk_en,
  output logic      periph_clk_en,
  output logic      osc_en,
  output logic      reg_lp,
  output logic      main_pwr_en,
  output logic      clk_sel_rc,
  output logic      sys_rst_req,
  output logic      sb_flag
);
  localparam int MAXC  = (SETTLE_CYC > RESTART_CYC) ? SETTLE_CYC : RESTART_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] RESTART_LD = CNT_W'(RESTART_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  lpm_mode_e        st_q, st_d, tgt;
  logic             wfe_q, wfe_d, lp_q, lp_d, ctx_ld;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, cnt_zero;
  logic             rc_q, rc_d, flag_q, flag_d;
  logic             go_low;

  assign tgt      = !cfg_deep ? M_SLEEP : (cfg_pdown ? M_STBY : M_STOP);
  assign go_low   = wfi_req | (wfe_req & ~evt_pend);
  assign cnt_zero = (cnt_q == '0);

  // Next-state logic
  always_comb begin
    st_d        = st_q;
    wfe_d       = wfe_q;
    lp_d        = lp_q;
    ctx_ld      = 1'b0;
    cnt_d       = cnt_q;
    cnt_en      = 1'b0;
    rc_d        = rc_q;
    flag_d      = flag_q;
    evt_consume = 1'b0;
    if (sb_flag_clr) flag_d = 1'b0;
    case (st_q)
      M_RUN: begin
        if (clk_main_req) rc_d = 1'b0;
        evt_consume = wfe_req & ~wfi_req;
        if (go_low) begin
          st_d   = tgt;
          wfe_d  = ~wfi_req;
          lp_d   = cfg_lpreg;
          ctx_ld = 1'b1;
        end else if (!wfe_req && handler_ret && cfg_soe) begin
          st_d   = M_SLEEP;
          wfe_d  = 1'b0;
          ctx_ld = 1'b1;
        end
      end
      M_SLEEP: begin
        if (irq_wake || (wfe_q && evt_now)) begin
          st_d        = M_RUN;
          evt_consume = wfe_q;
        end
      end
      M_STOP: begin
        if (ext_wake) begin
          rc_d = 1'b1;
          if (lp_q) begin
            st_d   = M_SETTLE;
            cnt_d  = SETTLE_LD;
            cnt_en = 1'b1;
          end else begin
            st_d = M_RUN;
          end
        end
      end
      M_SETTLE: begin
        if (cnt_zero) begin
          st_d = M_RUN;
        end else begin
          cnt_d  = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      M_STBY: begin
        if (stby_wake) begin
          st_d   = M_RESTART;
          cnt_d  = RESTART_LD;
          cnt_en = 1'b1;
          flag_d = 1'b1;
        end
      end
      M_RESTART: begin
        rc_d = 1'b1;
        if (cnt_zero) begin
          st_d = M_RUN;
        end else begin
          cnt_d  = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      default: st_d = M_RUN;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_RUN;
      rc_q   <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rc_q   <= rc_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wfe_q <= 1'b0;
      lp_q  <= 1'b0;
    end else if (ctx_ld) begin
      wfe_q <= wfe_d;
      lp_q  <= lp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Output decode from the state register
  always_comb begin
    core_clk_en   = 1'b0;
    periph_clk_en = 1'b0;
    osc_en        = 1'b0;
    reg_lp        = 1'b0;
    main_pwr_en   = 1'b0;
    sys_rst_req   = 1'b0;
    case (st_q)
      M_RUN: begin
        core_clk_en   = 1'b1;
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        main_pwr_en   = 1'b1;
      end
      M_SLEEP: begin
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        main_pwr_en   = 1'b1;
      end
      M_STOP: begin
        main_pwr_en = 1'b1;
        reg_lp      = lp_q;
      end
      M_SETTLE: begin
        osc_en      = 1'b1;
        main_pwr_en = 1'b1;
      end
      M_RESTART: begin
        osc_en      = 1'b1;
        main_pwr_en = 1'b1;
        sys_rst_req = 1'b1;
      end
      default: ;
    endcase
  end

  assign mode_o     = st_q;
  assign clk_sel_rc = rc_q;
  assign sb_flag    = flag_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NUM_IRQ     = 8,
  parameter int NUM_EXT     = 4,
  parameter int NUM_WPIN    = 2,
  parameter int NUM_BKP     = 4,
  parameter int SETTLE_CYC  = 6,
  parameter int RESTART_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_deep,
  input  logic                cfg_pdown,
  input  logic                cfg_lpreg,
  input  logic                cfg_sleep_on_ret,
  input  logic                cfg_pend_evt,
  input  logic                wfi_req,
  input  logic                wfe_req,
  input  logic                handler_ret,
  input  logic                evt_in,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  input  logic [NUM_IRQ-1:0]  irq_en,
  input  logic [NUM_EXT-1:0]  ext_line,
  input  logic [NUM_EXT-1:0]  ext_en,
  input  logic [NUM_WPIN-1:0] wpin,
  input  logic [NUM_WPIN-1:0] wpin_en,
  input  logic [NUM_BKP-1:0]  bkp_evt,
  input  logic                wdg_rst,
  input  logic                clk_main_req,
  input  logic                sb_flag_clr,
  output logic [2:0]          mode,
  output logic                core_clk_en,
  output logic                periph_clk_en,
  output logic                osc_en,
  output logic                reg_lp,
  output logic                main_pwr_en,
  output logic                clk_sel_rc,
  output logic                sys_rst_req,
  output logic                sb_flag
);
  import lpm_pkg::*;

  // Reset is asserted asynchronously and released on the clock.
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic      irq_wake, pend_rise, ext_wake, stby_wake;
  logic      evt_now, evt_pend, evt_consume;
  lpm_mode_e st;

  lpm_wake_src #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_EXT (NUM_EXT),
    .NUM_WPIN(NUM_WPIN),
    .NUM_BKP (NUM_BKP)
  ) wake_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .ext_line (ext_line),
    .ext_en   (ext_en),
    .wpin     (wpin),
    .wpin_en  (wpin_en),
    .bkp_evt  (bkp_evt),
    .wdg_rst  (wdg_rst),
    .irq_wake (irq_wake),
    .pend_rise(pend_rise),
    .ext_wake (ext_wake),
    .stby_wake(stby_wake)
  );

  lpm_event_reg evt_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .evt_in     (evt_in),
    .pend_rise  (pend_rise),
    .pend_evt_en(cfg_pend_evt),
    .consume    (evt_consume),
    .evt_now    (evt_now),
    .evt_pend   (evt_pend)
  );

  lpm_seq #(
    .SETTLE_CYC (SETTLE_CYC),
    .RESTART_CYC(RESTART_CYC)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cfg_deep     (cfg_deep),
    .cfg_pdown    (cfg_pdown),
    .cfg_lpreg    (cfg_lpreg),
    .cfg_soe      (cfg_sleep_on_ret),
    .wfi_req      (wfi_req),
    .wfe_req      (wfe_req),
    .handler_ret  (handler_ret),
    .irq_wake     (irq_wake),
    .ext_wake     (ext_wake),
    .stby_wake    (stby_wake),
    .evt_now      (evt_now),
    .evt_pend     (evt_pend),
    .clk_main_req (clk_main_req),
    .sb_flag_clr  (sb_flag_clr),
    .evt_consume  (evt_consume),
    .mode_o       (st),
    .core_clk_en  (core_clk_en),
    .periph_clk_en(periph_clk_en),
    .osc_en       (osc_en),
    .reg_lp       (reg_lp),
    .main_pwr_en  (main_pwr_en),
    .clk_sel_rc   (clk_sel_rc),
    .sys_rst_req  (sys_rst_req),
    .sb_flag      (sb_flag)
  );

  assign mode = st;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NUM_EXT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         mode,
  input logic               wfi_req,
  input logic               wfe_req,
  input logic               cfg_deep,
  input logic               cfg_sleep_on_ret,
  input logic               handler_ret,
  input logic [NUM_EXT-1:0] ext_line,
  input logic [NUM_EXT-1:0] ext_en,
  input logic               sys_rst_req,
  input logic               sb_flag,
  input logic               sb_flag_clr,
  input logic               clk_sel_rc,
  input logic               main_pwr_en,
  input logic               periph_clk_en
);
  localparam logic [2:0] C_RUN = 3'd0, C_SLEEP = 3'd1, C_STOP = 3'd2, C_STBY = 3'd3;

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C_RUN && wfi_req && !cfg_deep) |=> mode == C_SLEEP);

  p_stby_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C_STBY) |-> (!main_pwr_en && !periph_clk_en));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C_STOP && (ext_line & ext_en) == '0) |=> mode == C_STOP);

  p_rc_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == C_STOP && mode != C_STOP) |-> clk_sel_rc);

  p_rst_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(mode) == C_STBY);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_flag && !sb_flag_clr) |=> sb_flag);

  p_sleep_on_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C_RUN && handler_ret && cfg_sleep_on_ret && !wfi_req && !wfe_req)
      |=> mode == C_SLEEP);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_EXT(NUM_EXT)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode            (mode),
  .wfi_req         (wfi_req),
  .wfe_req         (wfe_req),
  .cfg_deep        (cfg_deep),
  .cfg_sleep_on_ret(cfg_sleep_on_ret),
  .handler_ret     (handler_ret),
  .ext_line        (ext_line),
  .ext_en          (ext_en),
  .sys_rst_req     (sys_rst_req),
  .sb_flag         (sb_flag),
  .sb_flag_clr     (sb_flag_clr),
  .clk_sel_rc      (clk_sel_rc),
  .main_pwr_en     (main_pwr_en),
  .periph_clk_en   (periph_clk_en)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb_top;
  localparam int NI = 8, NE = 4, NW = 2, NB = 4, SET_C = 6, RST_C = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_deep, cfg_pdown, cfg_lpreg, cfg_sleep_on_ret, cfg_pend_evt;
  logic wfi_req, wfe_req, handler_ret, evt_in, wdg_rst, clk_main_req, sb_flag_clr;
  logic [NI-1:0] irq_pend, irq_en;
  logic [NE-1:0] ext_line, ext_en;
  logic [NW-1:0] wpin, wpin_en;
  logic [NB-1:0] bkp_evt;
  logic [2:0] mode;
  logic core_clk_en, periph_clk_en, osc_en, reg_lp, main_pwr_en;
  logic clk_sel_rc, sys_rst_req, sb_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_ctrl #(.NUM_IRQ(NI), .NUM_EXT(NE), .NUM_WPIN(NW), .NUM_BKP(NB),
             .SETTLE_CYC(SET_C), .RESTART_CYC(RST_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_deep(cfg_deep), .cfg_pdown(cfg_pdown),
    .cfg_lpreg(cfg_lpreg), .cfg_sleep_on_ret(cfg_sleep_on_ret),
    .cfg_pend_evt(cfg_pend_evt), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .handler_ret(handler_ret), .evt_in(evt_in), .irq_pend(irq_pend),
    .irq_en(irq_en), .ext_line(ext_line), .ext_en(ext_en), .wpin(wpin),
    .wpin_en(wpin_en), .bkp_evt(bkp_evt), .wdg_rst(wdg_rst),
    .clk_main_req(clk_main_req), .sb_flag_clr(sb_flag_clr), .mode(mode),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .reg_lp(reg_lp), .main_pwr_en(main_pwr_en), .clk_sel_rc(clk_sel_rc),
    .sys_rst_req(sys_rst_req), .sb_flag(sb_flag));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_wfi();  wfi_req = 1'b1; step(); wfi_req = 1'b0; endtask
  task automatic do_wfe();  wfe_req = 1'b1; step(); wfe_req = 1'b0; endtask
  task automatic do_evt();  evt_in  = 1'b1; step(); evt_in  = 1'b0; endtask

  task automatic t_reset();
    chk("R1", "mode", mode, 0);
    chk("R1", "core clk", core_clk_en, 1);
    chk("R1", "periph clk", periph_clk_en, 1);
    chk("R1", "osc", osc_en, 1);
    chk("R1", "power", main_pwr_en, 1);
    chk("R1", "reg_lp", reg_lp, 0);
    chk("R1", "rc sel", clk_sel_rc, 1);
    chk("R1", "sys rst", sys_rst_req, 0);
    chk("R1", "flag", sb_flag, 0);
  endtask

  task automatic t_sleep_wfi();
    cfg_deep = 0; cfg_pdown = 0;
    do_wfi();
    chk("R2", "mode after wfi", mode, 1);
    chk("R2", "core clk off", core_clk_en, 0);
    chk("R2", "periph clk on", periph_clk_en, 1);
    irq_pend[3] = 1'b1; step();
    chk("R5", "masked irq ignored", mode, 1);
    irq_en[3] = 1'b1; step();
    chk("R5", "enabled irq wakes", mode, 0);
    irq_pend = '0; irq_en = '0; step();
  endtask

  task automatic t_stop_normal();
    clk_main_req = 1'b1; step(); clk_main_req = 1'b0;
    chk("R8", "main clock selected", clk_sel_rc, 0);
    cfg_deep = 1; cfg_pdown = 0; cfg_lpreg = 0;
    do_wfi();
    chk("R3", "mode stop", mode, 2);
    chk("R3", "core clk", core_clk_en, 0);
    chk("R3", "periph clk", periph_clk_en, 0);
    chk("R3", "osc", osc_en, 0);
    chk("R3", "reg_lp normal", reg_lp, 0);
    irq_pend[1] = 1'b1; irq_en[1] = 1'b1; wpin_en = 2'b01; wpin[0] = 1'b1;
    ext_line[1] = 1'b1; step(2);
    chk("R6", "irq/pin/masked line ignored", mode, 2);
    ext_en[1] = 1'b1; step();
    chk("R7", "normal regulator direct run", mode, 0);
    chk("R8", "rc after stop", clk_sel_rc, 1);
    irq_pend = '0; irq_en = '0; ext_line = '0; ext_en = '0; step();
  endtask

  task automatic t_stop_lp();
    cfg_deep = 1; cfg_pdown = 0; cfg_lpreg = 1;
    do_wfe();
    chk("R3", "mode stop via wfe", mode, 2);
    chk("R3", "reg_lp low-power", reg_lp, 1);
    cfg_lpreg = 0;
    ext_line[2] = 1'b1; ext_en[2] = 1'b1; step();
    ext_line = '0; ext_en = '0;
    for (int i = 0; i < SET_C; i++) begin
      chk("R7", "settle mode", mode, 4);
      chk("R7", "core clk held", core_clk_en, 0);
      step();
    end
    chk("R7", "run after settle", mode, 0);
  endtask

  task automatic t_stby_pin();
    cfg_deep = 1; cfg_pdown = 1;
    do_wfi();
    chk("R4", "mode standby", mode, 3);
    chk("R4", "power off", main_pwr_en, 0);
    chk("R4", "core clk", core_clk_en, 0);
    chk("R4", "osc", osc_en, 0);
    step(2);
    chk("R9", "pin high at entry ignored", mode, 3);
    wpin[1] = 1'b1; step();
    chk("R9", "disabled pin ignored", mode, 3);
    wpin[0] = 1'b0; step();
    chk("R9", "falling pin ignored", mode, 3);
    wpin[0] = 1'b1; step();
    for (int i = 0; i < RST_C; i++) begin
      chk("R10", "restart mode", mode, 5);
      chk("R10", "reset pulse", sys_rst_req, 1);
      step();
    end
    chk("R10", "run after restart", mode, 0);
    chk("R10", "reset released", sys_rst_req, 0);
    chk("R10", "flag sticky", sb_flag, 1);
    chk("R8", "rc after standby", clk_sel_rc, 1);
    step(3);
    chk("R10", "flag still set", sb_flag, 1);
    sb_flag_clr = 1'b1; step(); sb_flag_clr = 1'b0;
    chk("R10", "flag cleared", sb_flag, 0);
    wpin = '0; wpin_en = '0; step();
  endtask

  task automatic t_stby_other();
    cfg_deep = 1; cfg_pdown = 1;
    do_wfi();
    bkp_evt = 4'b0100; step(); bkp_evt = '0;
    chk("R9", "backup event wakes", mode, 5);
    step(RST_C);
    chk("R10", "run after backup wake", mode, 0);
    do_wfi();
    chk("R4", "standby again", mode, 3);
    wdg_rst = 1'b1; step(); wdg_rst = 1'b0;
    chk("R9", "watchdog wakes", mode, 5);
    step(RST_C);
    chk("R10", "run after watchdog", mode, 0);
    sb_flag_clr = 1'b1; step(); sb_flag_clr = 1'b0;
  endtask

  task automatic t_sleep_on_ret();
    cfg_deep = 0; cfg_pdown = 0; cfg_sleep_on_ret = 0;
    handler_ret = 1'b1; step(); handler_ret = 1'b0;
    chk("R11", "no sleep when option off", mode, 0);
    cfg_sleep_on_ret = 1;
    handler_ret = 1'b1; step(); handler_ret = 1'b0;
    chk("R11", "sleep on return", mode, 1);
    irq_pend[2] = 1'b1; irq_en[2] = 1'b1; step();
    chk("R5", "wake from return sleep", mode, 0);
    irq_pend = '0; irq_en = '0; cfg_sleep_on_ret = 0; step();
  endtask

  task automatic t_wfe_events();
    cfg_deep = 0; cfg_pend_evt = 0;
    do_wfe();
    chk("R2", "sleep via wfe", mode, 1);
    irq_pend[5] = 1'b1; step();
    chk("R12", "new pending ignored when option off", mode, 1);
    irq_pend[5] = 1'b0; step();
    do_evt();
    chk("R12", "event wakes wfe", mode, 0);
    cfg_pend_evt = 1;
    do_wfe();
    chk("R12", "sleep via wfe again", mode, 1);
    irq_pend[6] = 1'b1; step();
    chk("R12", "new pending wakes", mode, 0);
    irq_pend = '0; cfg_pend_evt = 0; step();
  endtask

  task automatic t_wfe_record();
    cfg_deep = 0;
    do_evt(); step(3);
    do_wfe();
    chk("R13", "recorded event skips wfe", mode, 0);
    do_wfe();
    chk("R13", "second wfe sleeps", mode, 1);
    do_evt();
    chk("R12", "event wakes", mode, 0);
    wfe_req = 1'b1; evt_in = 1'b1; step(); wfe_req = 1'b0; evt_in = 1'b0;
    chk("R13", "same-cycle event skips wfe", mode, 0);
    do_wfe();
    chk("R13", "record cleared, wfe sleeps", mode, 1);
    do_evt();
    chk("R12", "final wake", mode, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_deep = 0; cfg_pdown = 0; cfg_lpreg = 0; cfg_sleep_on_ret = 0; cfg_pend_evt = 0;
    wfi_req = 0; wfe_req = 0; handler_ret = 0; evt_in = 0; wdg_rst = 0;
    clk_main_req = 0; sb_flag_clr = 0;
    irq_pend = '0; irq_en = '0; ext_line = '0; ext_en = '0;
    wpin = '0; wpin_en = '0; bkp_evt = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_sleep_wfi();
    t_stop_normal();
    t_stop_lp();
    t_stby_pin();
    t_stby_other();
    t_sleep_on_ret();
    t_wfe_events();
    t_wfe_record();
    done = 1;
    summary();
    $finish;
  end
endmodule